// File: doc/BRIEF.md
# Canonical Huffman Symbol Decoder

This block turns a packed stream of variable-length prefix codewords into decoded symbols. Compressed data enters as 32-bit words, most significant bit first. The words collect in a bit buffer, and the first unread bit of the stream sits at the top of that buffer. In each cycle the block finds the length of the codeword at the head of the buffer by comparing it against the largest code of every length. It reads the symbol from a compact table and pulls out the magnitude bits that follow the codeword. It then presents the symbol together with its signed coefficient value.

The symbol table is held in order of code length, and codes of the same length sit in order of value. A lookup address is formed from two parts. One is a base chosen by the matched length. The other is an offset cut from the codeword by a shifter whose shift is set only by the length. A per-length mask of low-order ones then trims that offset. The code-length counts and the symbol list are fixed parameters. Each symbol is a byte: the upper nibble holds a zero-run count and the lower nibble holds the magnitude size. The output uses a valid/ready handshake.

Top module: `huff_symbol_decoder`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high.
- R2: `in_ready` is high exactly when fewer than 27 unread bits are held. A word is taken on a cycle where both `in_valid` and `in_ready` are high, and its bit 31 is read first.
- R3: The codeword length is the shortest length L whose L head bits do not exceed the largest code of that length. The codes are canonical: each length starts at twice the code value that follows the last code of the length below.
- R4: The symbol output for the k-th code of length L, counting from 0, is table entry (number of codes shorter than L) + k.
- R5: When the size nibble is S > 0, the S bits after the codeword are the magnitude. If its leading bit is 1, the value is those bits read as a positive number.
- R6: If the leading magnitude bit is 0, the value is the raw bits minus (2^S − 1), which gives a negative result.
- R7: A symbol whose size nibble is 0 consumes no magnitude bits and reports a value of 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_sym` and `out_val` hold steady. No symbol is dropped or repeated.
- R9: A symbol is issued in the first cycle in which its codeword and magnitude bits are all buffered and the output register is free. Head bits that begin no valid codeword produce no output.
- R10: A 16-bit codeword that carries an 11-bit magnitude, which is the longest unit of 27 bits, decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Compressed word, MSB first |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Buffer can take a word |
| out_sym | output | 8 | Decoded run/size symbol |
| out_val | output | 16 | Signed coefficient value |
| out_valid | output | 1 | Output symbol is valid |
| out_ready | input | 1 | Consumer takes the symbol |

## Verification
The assertions watch the output on every cycle. They check that it holds while stalled, that zero-size symbols carry a zero value, and that every nonzero value lies within the range its size nibble allows. They also check that the buffer fill never goes past its capacity and never grows by more than one word per cycle. Whether the right symbol comes out, in which cycle, and which magnitude bits it took can only be shown by the bench. The bench encodes known symbol sequences and runs them against a bit-count model under randomly varied input gaps and output stalls, including an all-ones tail that matches no codeword.

// File: rtl/huff_symbol_decoder.sv
module huff_symbol_decoder #(
  parameter int MAX_LEN = 16,
  parameter int MAG_MAX = 11,
  parameter int WIN = 19,
  parameter int OFF_W = 9,
  parameter int NSYM = 12,
  parameter int VAL_W = 16,
  parameter logic [7:0] LEN_COUNT [MAX_LEN] =
    '{8'd0, 8'd2, 8'd1, 8'd3, 8'd2, 8'd0, 8'd1, 8'd0,
      8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2},
  parameter logic [7:0] SYMS [NSYM] =
    '{8'h01, 8'h02, 8'h03, 8'h00, 8'h04, 8'h11,
      8'h05, 8'h12, 8'h21, 8'h0A, 8'hF0, 8'h0B}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [31:0]             in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [7:0]              out_sym,
  output logic signed [VAL_W-1:0] out_val,
  output logic                    out_valid,
  input  logic                    out_ready
);
  localparam int NEED = MAX_LEN + MAG_MAX;
  localparam int BUF_W = NEED + 31;
  localparam int CW = $clog2(BUF_W + 1);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int UW = $clog2(NEED + 1);
  localparam int AW = (NSYM > 1) ? $clog2(NSYM) : 1;
  localparam int CODE_W = MAX_LEN + 1;

  logic [BUF_W-1:0] bits;
  logic [CW-1:0] cnt;

  logic [CODE_W-1:0] first_c [MAX_LEN];
  logic [CODE_W-1:0] last_c [MAX_LEN];
  logic [OFF_W-1:0] off_mask [MAX_LEN];
  logic [AW-1:0] rel_base [MAX_LEN];

  always_comb begin : tables
    logic [CODE_W-1:0] c;
    int idx;
    int k;
    c = '0;
    idx = 0;
    for (int l = 0; l < MAX_LEN; l++) begin
      c = c << 1;
      first_c[l] = c;
      last_c[l] = c + CODE_W'(LEN_COUNT[l]) - CODE_W'(1);
      k = 0;
      for (int b = 0; b < OFF_W; b++)
        if ((first_c[l] >> b) != (last_c[l] >> b)) k = b + 1;
      off_mask[l] = OFF_W'((1 << k) - 1);
      rel_base[l] = AW'(idx) - AW'(first_c[l] & CODE_W'(off_mask[l]));
      c = c + CODE_W'(LEN_COUNT[l]);
      idx = idx + int'(LEN_COUNT[l]);
    end
  end

  logic hit;
  logic [LW-1:0] len;
  always_comb begin
    hit = 1'b0;
    len = '0;
    for (int l = MAX_LEN - 1; l >= 0; l--)
      if (LEN_COUNT[l] != 8'd0 &&
          CODE_W'(bits[BUF_W-1 -: MAX_LEN] >> (MAX_LEN - 1 - l)) <= last_c[l]) begin
        hit = 1'b1;
        len = LW'(l + 1);
      end
  end

  logic [LW-1:0] lidx;
  logic [OFF_W-1:0] offset;
  logic [AW-1:0] addr;
  logic [7:0] sym;
  logic [3:0] size;
  logic [UW-1:0] used;
  logic [MAG_MAX-1:0] raw;
  logic signed [VAL_W-1:0] value;

  assign lidx   = hit ? len - LW'(1) : '0;
  assign offset = OFF_W'(bits[BUF_W-1 -: WIN] >> (WIN - int'(len))) & off_mask[lidx];
  assign addr   = rel_base[lidx] + AW'(offset);
  assign sym    = (int'(addr) < NSYM) ? SYMS[addr] : 8'h00;
  assign size   = sym[3:0];
  assign used   = UW'(len) + UW'(size);
  assign raw    = MAG_MAX'((bits << len) >> (BUF_W - MAG_MAX)) >> (MAG_MAX - int'(size));

  always_comb begin
    if (size == 4'd0)
      value = '0;
    else if (((raw >> (size - 4'd1)) & MAG_MAX'(1)) != '0)
      value = VAL_W'(raw);
    else
      value = VAL_W'(raw) - VAL_W'((1 << size) - 1);
  end

  logic fire, accept;
  logic [CW-1:0] left;
  assign in_ready = cnt < CW'(NEED);
  assign accept   = in_valid && in_ready;
  assign fire     = hit && (cnt >= CW'(used)) && (!out_valid || out_ready);
  assign left     = fire ? cnt - CW'(used) : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
      cnt <= '0;
      out_valid <= 1'b0;
      out_sym <= '0;
      out_val <= '0;
    end else begin
      bits <= (fire ? bits << used : bits) |
              (accept ? ({in_data, (BUF_W-32)'(0)} >> left) : '0);
      cnt <= left + (accept ? CW'(32) : CW'(0));
      if (fire) begin
        out_valid <= 1'b1;
        out_sym <= sym;
        out_val <= value;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/huff_symbol_decoder_chk.sv
module huff_symbol_decoder_chk #(
  parameter int VAL_W = 16,
  parameter int BUF_W = 58
) (
  input logic                    clk,
  input logic                    rst,
  input logic [$clog2(BUF_W+1)-1:0] cnt,
  input logic [7:0]              out_sym,
  input logic signed [VAL_W-1:0] out_val,
  input logic                    out_valid,
  input logic                    out_ready
);
  logic [VAL_W-1:0] mag;
  assign mag = out_val[VAL_W-1] ? VAL_W'(-out_val) : VAL_W'(out_val);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_val));

  // R7
  zero_size_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sym[3:0] == 4'd0 |-> out_val == '0);

  // R5 R6
  mag_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sym[3:0] != 4'd0 |->
      int'(mag) >= (1 << (out_sym[3:0] - 4'd1)) && int'(mag) <= ((1 << out_sym[3:0]) - 1));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= BUF_W);

  // R2
  refill_step_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= int'($past(cnt)) + 32);
endmodule

bind huff_symbol_decoder huff_symbol_decoder_chk #(.VAL_W(VAL_W), .BUF_W(BUF_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .out_sym(out_sym), .out_val(out_val),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/huff_symbol_decoder_test.sv
`timescale 1ns/1ps
module huff_symbol_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] out_sym;
  logic signed [15:0] out_val;
  logic out_valid;
  logic out_ready = 1'b0;

  huff_symbol_decoder uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_sym(out_sym), .out_val(out_val), .out_valid(out_valid), .out_ready(out_ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  int t_sym [12] = '{8'h01, 8'h02, 8'h03, 8'h00, 8'h04, 8'h11, 8'h05, 8'h12, 8'h21, 8'h0A, 8'hF0, 8'h0B};
  int t_code[12] = '{0, 1, 4, 10, 11, 12, 26, 27, 112, 452, 16'hE280, 16'hE281};
  int t_len [12] = '{2, 2, 3, 4, 4, 4, 5, 5, 7, 9, 16, 16};

  bit bq[$];
  int words[$];
  int ev_sym[$], ev_val[$], ev_len[$], ev_need[$];
  int mcnt, k, kout, wi;
  bit mvalid;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rand_val(int size);
    int m;
    if (size == 0) return 0;
    m = (1 << (size - 1)) + int'($urandom_range((1 << (size - 1)) - 1, 0));
    return ($urandom_range(1, 0) == 1) ? m : -m;
  endfunction

  task automatic clear_stream();
    bq.delete(); words.delete();
    ev_sym.delete(); ev_val.delete(); ev_len.delete(); ev_need.delete();
  endtask

  task automatic add_sym(int idx, int val);
    int size;
    int m;
    size = t_sym[idx] & 15;
    for (int b = t_len[idx] - 1; b >= 0; b--) bq.push_back(bit'((t_code[idx] >> b) & 1));
    if (size > 0) begin
      m = (val > 0) ? val : val + (1 << size) - 1;
      for (int b = size - 1; b >= 0; b--) bq.push_back(bit'((m >> b) & 1));
    end
    ev_sym.push_back(t_sym[idx]);
    ev_val.push_back(val);
    ev_len.push_back(t_len[idx]);
    ev_need.push_back(t_len[idx] + size);
  endtask

  task automatic pack();
    while (bq.size() % 32 != 0) bq.push_back(1'b1);
    for (int w = 0; w < bq.size() / 32; w++) begin
      int v = 0;
      for (int b = 0; b < 32; b++) v = (v << 1) | int'(bq[w*32 + b]);
      words.push_back(v);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 0; k = 0; kout = 0; wi = 0; mvalid = 1'b0;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic step(int pin, int pout);
    int size;
    bit acc, fire;
    chk(in_ready == (mcnt < 27), "R2 in_ready", int'(in_ready), int'(mcnt < 27));
    chk(out_valid == mvalid, (kout >= ev_sym.size()) ? "R9 out_valid" : "R8 R9 out_valid",
        int'(out_valid), int'(mvalid));
    if (mvalid && out_valid) begin
      size = ev_sym[kout] & 15;
      chk(int'(out_sym) == ev_sym[kout], (ev_len[kout] == 16) ? "R10 symbol" : "R3 R4 symbol",
          int'(out_sym), ev_sym[kout]);
      chk(int'(out_val) == ev_val[kout],
          (size == 0) ? "R7 value" : (ev_val[kout] > 0) ? "R5 value" : "R6 value",
          int'(out_val), ev_val[kout]);
    end
    in_valid = (wi < words.size()) && ($urandom_range(99, 0) < pin);
    in_data = in_valid ? words[wi] : $urandom;
    out_ready = ($urandom_range(99, 0) < pout);
    acc = in_valid && (mcnt < 27);
    fire = (!mvalid || out_ready) && (k < ev_sym.size()) && (k < ev_need.size()) && (mcnt >= ev_need[k]);
    if (mvalid && out_ready) kout++;
    mcnt = mcnt - (fire ? ev_need[k] : 0) + (acc ? 32 : 0);
    mvalid = fire ? 1'b1 : (mvalid && !out_ready);
    if (fire) k++;
    if (acc) wi++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int pin, int pout);
    int guard = 0;
    pack();
    while (!(kout == ev_sym.size() && wi == words.size()) && guard < 40000) begin
      step(pin, pout);
      guard++;
    end
    for (int i = 0; i < 12; i++) step(100, 100);
    chk(kout == ev_sym.size(), "R9 symbols delivered", kout, ev_sym.size());
  endtask

  initial begin
    do_reset();
    clear_stream();
    for (int i = 0; i < 12; i++) add_sym(i, rand_val(t_sym[i] & 15));
    for (int i = 11; i >= 0; i--) add_sym(i, rand_val(t_sym[i] & 15));
    run(100, 100);

    do_reset();
    clear_stream();
    for (int i = 0; i < 300; i++) begin
      int idx = int'($urandom_range(11, 0));
      add_sym(idx, rand_val(t_sym[idx] & 15));
    end
    run(60, 50);

    do_reset();
    clear_stream();
    add_sym(11, 1024); add_sym(11, -1024); add_sym(11, 2047); add_sym(11, -2047);
    add_sym(9, 512); add_sym(9, -1023); add_sym(0, 1); add_sym(0, -1);
    add_sym(10, 0); add_sym(3, 0); add_sym(10, 0); add_sym(1, -3); add_sym(1, 2);
    for (int i = 0; i < 20; i++) add_sym(11, rand_val(11));
    run(100, 30);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule